// File: doc/BRIEF.md
# SMBus Configuration Register Slave

This block is a two-wire serial slave that exposes a bank of twenty-two 8-bit configuration registers to a bus master. The bus lines are seen as resolved input levels. The slave pulls the data line low through an open-drain style enable and never drives the clock line. Both lines are oversampled by the block's own clock through a synchronizer. Start, stop and clock-edge events are derived from the synchronized levels.

The first byte after the address is a command. When its top bit is set, the low seven bits select one register for an indexed access. When its top bit is clear, the transfer is sequential and starts at register 0.

- A sequential write carries a byte count, which is acknowledged and discarded, and then data for registers 0, 1, 2 and onward.
- A sequential read first returns the contents of the count register (offset 15), then registers from 0 upward until the master stops acknowledging.
- Reads switch direction with a repeated start. Data travels most significant bit first. Any transfer may end after a whole byte.
- Offsets 4 to 9 mirror a hardware divider input, and offset 10 mirrors a hardware status input.
- Offsets 11 to 14 are fixed. The remaining bytes hold configuration with power-up defaults, and the whole bank is presented on a flat output bus.

The link state machine has seven states:

- IDLE: the bus is free.
- ADDR: shifting in the address byte.
- ACK: the slave drives an acknowledge.
- RX: shifting in a command or data byte.
- TX: shifting out a byte.
- TXACK: sampling the master's acknowledge.
- WAIT: ignoring the bus until the next start or stop.

Its transitions are:

- Any state goes to ADDR on a start and to IDLE on a stop.
- ADDR goes to ACK when the eighth bit matches the device address, and to WAIT when it does not.
- ACK goes to TX after a read address, and to RX otherwise.
- RX goes to ACK after eight bits.
- TX goes to TXACK after eight bits.
- TXACK goes to TX when the master acknowledges, and to WAIT when it does not.

Top module: `smbus_cfg_slave`

## Requirements
- R1: After reset, the bank reads as follows. Offset 0 = 0xEF, 1 = 0xC0, 2 = 0xFF, 3 = 0x30, 11 = 0x81, 12 = 0xA0, 15 = 0x16 and 16 = 0x40. Offsets 13, 14 and 17 to 21 are 0x00.
- R2: The slave acknowledges an address byte of 0xD2 (write) or 0xD3 (read), that is device address 0x69. It leaves every byte of a frame with any other address unacknowledged and changes no register.
- R3: Command bit 7 = 1 selects indexed access at the offset in bits 6:0. Bit 7 = 0 selects sequential access from offset 0 whatever bits 6:0 hold.
- R4: An indexed write stores each data byte at the selected offset, and further bytes in the same frame go to the next offsets.
- R5: A sequential write acknowledges the count byte without storing it. It then stores data at offsets 0, 1, 2 and onward. A stop after any whole byte leaves later offsets unchanged.
- R6: An indexed read (command, repeated start, 0xD3) returns the selected register, most significant bit first.
- R7: A sequential read returns the value of offset 15 first, then offsets 0, 1, 2 and onward while the master acknowledges. A master NACK ends the data, and the slave releases SDA.
- R8: Offsets 4 to 9 return hw_div byte (offset-4), least significant byte at offset 4. Offset 10 returns {hw_stat, 3'b000}. Writes are acknowledged, but only these bits change: offset 1 bits 7:3, offset 3 bits 5:4 and 2:0, offset 16 bits 7:6, offset 19 bits 5:0, and all bits of offsets 0, 2, 15, 17, 18, 20 and 21.
- R9: Offsets 22 to 127 read 0xFF and ignore writes. The offset counter stops advancing at 127.
- R10: The slave starts pulling SDA low only while SCL is low.
- R11: A stop returns the slave to idle with SDA released, even in the middle of a byte, and a byte cut short this way writes nothing. A repeated start keeps the offset and access mode.
- R12: The bank changes only when a received data byte completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Resolved serial clock line level |
| sda_i | input | 1 | Resolved serial data line level |
| sda_oe | output | 1 | 1 = pull SDA low |
| hw_div | input | 48 | Hardware divider values for offsets 4 to 9 |
| hw_stat | input | 5 | Hardware status bits for offset 10 bits 7:3 |
| cfg_bytes | output | 176 | Whole bank, byte i at bits 8i+7:8i |

## Verification
A stop condition can arrive in the same cycle in which a partly shifted byte would otherwise be taken as complete. The start/stop detector must then win over the byte logic. The bench provokes this by aborting frames with a stop after four address bits and after five data bits. Every clock, a behavioural model of the bank is compared with `cfg_bytes` to show that nothing was written. A following indexed read then confirms that the slave came back to idle and still answers normally.

// File: rtl/smbcfg_pkg.sv
package smbcfg_pkg;

    localparam int REG_COUNT    = 22;
    localparam int OFF_W        = 7;
    localparam int IDX_W        = $clog2(REG_COUNT);
    localparam int CFG_W        = 8 * REG_COUNT;
    localparam int HW_DIV_FIRST = 4;
    localparam int HW_DIV_BYTES = 6;
    localparam int HW_DIV_W     = 8 * HW_DIV_BYTES;
    localparam int HW_STAT_IDX  = 10;
    localparam int HW_STAT_W    = 5;
    localparam int COUNT_IDX    = 15;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK,
        ST_RX,
        ST_TX,
        ST_TXACK,
        ST_WAIT
    } link_state_t;

    typedef enum logic [1:0] {
        PH_CMD,
        PH_COUNT,
        PH_DATA
    } rx_phase_t;

    // power-up value of each byte
    function automatic logic [7:0] reg_default(input int idx);
        case (idx)
            0:       return 8'hEF;
            1:       return 8'hC0;
            2:       return 8'hFF;
            3:       return 8'h30;
            11:      return 8'h81;
            12:      return 8'hA0;
            15:      return 8'h16;
            16:      return 8'h40;
            default: return 8'h00;
        endcase
    endfunction

    // bits a bus write may change
    function automatic logic [7:0] reg_wmask(input int idx);
        case (idx)
            0, 2, 15, 17, 18, 20, 21: return 8'hFF;
            1:       return 8'hF8;
            3:       return 8'h37;
            16:      return 8'hC0;
            19:      return 8'h3F;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [CFG_W-1:0] rw_bits();
        logic [CFG_W-1:0] m;
        m = '0;
        for (int i = 0; i < REG_COUNT; i++) m[8*i +: 8] = reg_wmask(i);
        return m;
    endfunction

endpackage

// File: rtl/smbcfg_sync_edge.sv
module smbcfg_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);

    logic [STAGES-1:0] scl_q;
    logic [STAGES-1:0] sda_q;
    logic              scl_p;
    logic              sda_p;
    logic              scl_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_q <= {scl_q[STAGES-2:0], scl_i};
            sda_q <= {sda_q[STAGES-2:0], sda_i};
            scl_p <= scl_q[STAGES-1];
            sda_p <= sda_q[STAGES-1];
        end
    end

    assign scl_s     = scl_q[STAGES-1];
    assign sda_s     = sda_q[STAGES-1];
    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign bus_start = scl_s & scl_p & sda_p & ~sda_s;
    assign bus_stop  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/smbcfg_regbank.sv
module smbcfg_regbank
    import smbcfg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [OFF_W-1:0]     wr_off,
    input  logic [7:0]           wr_data,
    input  logic [OFF_W-1:0]     rd_off,
    output logic [7:0]           rd_data,
    input  logic [HW_DIV_W-1:0]  hw_div,
    input  logic [HW_STAT_W-1:0] hw_stat,
    output logic [CFG_W-1:0]     cfg_bytes
);

    logic [7:0] bytes_w [REG_COUNT];

    for (genvar i = 0; i < REG_COUNT; i++) begin : g_reg
        localparam logic [7:0] WM = reg_wmask(i);
        localparam logic [7:0] DV = reg_default(i);
        if (WM != 8'h00) begin : g_rw
            logic [7:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q <= DV;
                end else if (wr_en && wr_off == OFF_W'(i)) begin
                    q <= (q & ~WM) | (wr_data & WM);
                end
            end
            assign bytes_w[i] = q;
        end else if (i >= HW_DIV_FIRST && i < HW_DIV_FIRST + HW_DIV_BYTES) begin : g_div
            assign bytes_w[i] = hw_div[8*(i-HW_DIV_FIRST) +: 8];
        end else if (i == HW_STAT_IDX) begin : g_stat
            assign bytes_w[i] = {hw_stat, {(8-HW_STAT_W){1'b0}}};
        end else begin : g_const
            assign bytes_w[i] = DV;
        end
        assign cfg_bytes[8*i +: 8] = bytes_w[i];
    end

    always_comb begin
        rd_data = 8'hFF;
        if (rd_off < OFF_W'(REG_COUNT)) rd_data = bytes_w[rd_off[IDX_W-1:0]];
    end

endmodule

// File: rtl/smbcfg_link.sv
module smbcfg_link
    import smbcfg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h69
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sda_s,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             bus_start,
    input  logic             bus_stop,
    input  logic [7:0]       rd_data,
    output logic [OFF_W-1:0] rd_off,
    output logic             wr_en,
    output logic [OFF_W-1:0] wr_off,
    output logic [7:0]       wr_data,
    output logic             sda_oe,
    output link_state_t      state_o
);

    link_state_t      state, state_d;
    rx_phase_t        phase;
    logic [7:0]       shreg;
    logic [3:0]       bitcnt;
    logic [OFF_W-1:0] ptr;
    logic             tx_after;
    logic             cnt_pend;
    logic             mack;
    logic             addr_hit;
    logic             byte_done;
    logic [OFF_W-1:0] ptr_inc;

    assign addr_hit  = (shreg[7:1] == DEV_ADDR);
    assign byte_done = scl_fall && (bitcnt == 4'd8);
    assign ptr_inc   = (ptr == {OFF_W{1'b1}}) ? ptr : ptr + 1'b1;

    // next state
    always_comb begin
        state_d = state;
        if (bus_stop) begin
            state_d = ST_IDLE;
        end else if (bus_start) begin
            state_d = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE:  state_d = ST_IDLE;
                ST_WAIT:  state_d = ST_WAIT;
                ST_ADDR:  if (byte_done) state_d = addr_hit ? ST_ACK : ST_WAIT;
                ST_ACK:   if (scl_fall) state_d = tx_after ? ST_TX : ST_RX;
                ST_RX:    if (byte_done) state_d = ST_ACK;
                ST_TX:    if (scl_fall && bitcnt == 4'd7) state_d = ST_TXACK;
                ST_TXACK: if (scl_fall) state_d = mack ? ST_TX : ST_WAIT;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase    <= PH_CMD;
            shreg    <= '0;
            bitcnt   <= '0;
            ptr      <= '0;
            tx_after <= 1'b0;
            cnt_pend <= 1'b0;
            mack     <= 1'b0;
        end else if (bus_start || bus_stop) begin
            bitcnt   <= '0;
            cnt_pend <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE, ST_WAIT: begin
                    bitcnt <= '0;
                end
                ST_ADDR: begin
                    if (scl_rise) begin
                        shreg  <= {shreg[6:0], sda_s};
                        bitcnt <= bitcnt + 4'd1;
                    end
                    if (byte_done) begin
                        tx_after <= shreg[0];
                        cnt_pend <= shreg[0] & ~phase_is_idx;
                        phase    <= PH_CMD;
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        bitcnt <= '0;
                        if (tx_after) shreg <= rd_data;
                    end
                end
                ST_RX: begin
                    if (scl_rise) begin
                        shreg  <= {shreg[6:0], sda_s};
                        bitcnt <= bitcnt + 4'd1;
                    end
                    if (byte_done) begin
                        tx_after <= 1'b0;
                        unique case (phase)
                            PH_CMD: begin
                                ptr   <= shreg[7] ? shreg[6:0] : '0;
                                phase <= shreg[7] ? PH_DATA : PH_COUNT;
                            end
                            PH_COUNT: phase <= PH_DATA;
                            PH_DATA:  ptr   <= ptr_inc;
                            default:  phase <= PH_CMD;
                        endcase
                    end
                end
                ST_TX: begin
                    if (scl_fall && bitcnt != 4'd7) begin
                        shreg  <= {shreg[6:0], 1'b0};
                        bitcnt <= bitcnt + 4'd1;
                    end
                end
                ST_TXACK: begin
                    if (scl_rise) begin
                        mack <= ~sda_s;
                        if (!sda_s) begin
                            if (cnt_pend) cnt_pend <= 1'b0;
                            else          ptr      <= ptr_inc;
                        end
                    end
                    if (scl_fall) begin
                        bitcnt <= '0;
                        if (mack) shreg <= rd_data;
                    end
                end
                default: bitcnt <= '0;
            endcase
        end
    end

    // access mode kept from the last command: indexed when the command's top bit was set
    logic phase_is_idx;
    logic idx_mode;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                         idx_mode <= 1'b1;
        else if (state == ST_RX && byte_done && phase == PH_CMD && !bus_start && !bus_stop)
                                                            idx_mode <= shreg[7];
    end
    assign phase_is_idx = idx_mode;

    // outputs
    always_comb begin
        wr_en   = (state == ST_RX) && byte_done && (phase == PH_DATA) && !bus_start && !bus_stop;
        wr_off  = ptr;
        wr_data = shreg;
        rd_off  = cnt_pend ? OFF_W'(COUNT_IDX) : ptr;
        sda_oe  = (state == ST_ACK) || ((state == ST_TX) && !shreg[7]);
        state_o = state;
    end

endmodule

// File: rtl/smbus_cfg_slave.sv
module smbus_cfg_slave
    import smbcfg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h69,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scl_i,
    input  logic                 sda_i,
    output logic                 sda_oe,
    input  logic [HW_DIV_W-1:0]  hw_div,
    input  logic [HW_STAT_W-1:0] hw_stat,
    output logic [CFG_W-1:0]     cfg_bytes
);

    logic             sda_s;
    logic             scl_rise;
    logic             scl_fall;
    logic             bus_start;
    logic             bus_stop;
    logic [7:0]       rd_data;
    logic [OFF_W-1:0] rd_off;
    logic             wr_en;
    logic [OFF_W-1:0] wr_off;
    logic [7:0]       wr_data;
    link_state_t      state_w;

    smbcfg_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .bus_start (bus_start),
        .bus_stop  (bus_stop)
    );

    smbcfg_link #(.DEV_ADDR(DEV_ADDR)) u_link (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .bus_start (bus_start),
        .bus_stop  (bus_stop),
        .rd_data   (rd_data),
        .rd_off    (rd_off),
        .wr_en     (wr_en),
        .wr_off    (wr_off),
        .wr_data   (wr_data),
        .sda_oe    (sda_oe),
        .state_o   (state_w)
    );

    smbcfg_regbank u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_off    (wr_off),
        .wr_data   (wr_data),
        .rd_off    (rd_off),
        .rd_data   (rd_data),
        .hw_div    (hw_div),
        .hw_stat   (hw_stat),
        .cfg_bytes (cfg_bytes)
    );

endmodule

// File: rtl/smbus_cfg_slave_chk.sv
module smbus_cfg_slave_chk
    import smbcfg_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             scl_i,
    input logic             sda_oe,
    input logic [CFG_W-1:0] cfg_bytes,
    input link_state_t      state_w
);

    localparam logic [CFG_W-1:0] RWM = rw_bits();

    // R10: the pull-down is switched on only while SCL is low
    a_r10_drive_on_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_i);

    // R11: SDA is released whenever the link is idle or waiting
    a_r11_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (state_w == ST_IDLE || state_w == ST_WAIT) |-> !sda_oe);

    // R12: writable bits move only as a received byte completes
    a_r12_write_after_rx: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_bytes & RWM) |-> $past(state_w) == ST_RX);

    // R2: an acknowledge follows only an address or a received byte
    a_r2_ack_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (state_w == ST_ACK && $past(state_w) != ST_ACK)
            |-> ($past(state_w) == ST_ADDR || $past(state_w) == ST_RX));

    // R7: transmission starts only after an acknowledge phase
    a_r7_tx_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (state_w == ST_TX && $past(state_w) != ST_TX)
            |-> ($past(state_w) == ST_ACK || $past(state_w) == ST_TXACK));

endmodule

bind smbus_cfg_slave smbus_cfg_slave_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_oe    (sda_oe),
    .cfg_bytes (cfg_bytes),
    .state_w   (state_w)
);

// File: tb/smbus_cfg_slave_test.sv
module smbus_cfg_slave_test;

    localparam int Q = 6;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         scl = 1'b1;
    logic         sda_low = 1'b0;
    logic         sda_oe;
    logic [47:0]  hw_div = 48'h9C3A77102FE4;
    logic [4:0]   hw_stat = 5'b10110;
    logic [175:0] cfg;
    logic [175:0] exp_flat;
    wire          sda_bus = !(sda_low || sda_oe);

    int           checks = 0;
    int           errors = 0;
    bit           cmp_on = 1'b0;
    bit           done = 1'b0;
    logic [7:0]   m [22];

    always #2.5 clk = ~clk;

    smbus_cfg_slave uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl),
        .sda_i     (sda_bus),
        .sda_oe    (sda_oe),
        .hw_div    (hw_div),
        .hw_stat   (hw_stat),
        .cfg_bytes (cfg)
    );

    // expected power-up values (R1)
    function automatic logic [7:0] bdef(input int i);
        case (i)
            0: return 8'hEF;  1: return 8'hC0;  2: return 8'hFF;  3: return 8'h30;
            11: return 8'h81; 12: return 8'hA0; 15: return 8'h16; 16: return 8'h40;
            default: return 8'h00;
        endcase
    endfunction

    // writable bits (R8)
    function automatic logic [7:0] bwm(input int i);
        case (i)
            0, 2, 15, 17, 18, 20, 21: return 8'hFF;
            1: return 8'hF8;  3: return 8'h37;  16: return 8'hC0;  19: return 8'h3F;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] model_byte(input int i);
        if (i > 21)            return 8'hFF;
        if (i >= 4 && i <= 9)  return hw_div[8*(i-4) +: 8];
        if (i == 10)           return {hw_stat, 3'b000};
        return m[i];
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    // whole bank compared with the model on every clock while the bus is quiet (R12)
    always @(negedge clk) begin
        if (cmp_on) begin
            for (int i = 0; i < 22; i++) exp_flat[8*i +: 8] = model_byte(i);
            checks++;
            if (cfg !== exp_flat) begin
                errors++;
                if (errors < 10) $display("FAIL R12 bank: got %h expected %h", cfg, exp_flat);
            end
        end
    end

    task automatic wait_q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic send_start();
        sda_low = 1'b0; wait_q();
        scl = 1'b1;     wait_q();
        sda_low = 1'b1; wait_q();
        scl = 1'b0;     wait_q();
    endtask

    task automatic send_stop();
        sda_low = 1'b1; wait_q();
        scl = 1'b1;     wait_q();
        sda_low = 1'b0; wait_q();
    endtask

    task automatic put_bit(input logic b);
        sda_low = !b; wait_q();
        scl = 1'b1;   wait_q();
        scl = 1'b0;   wait_q();
    endtask

    task automatic get_bit(output logic b);
        sda_low = 1'b0; wait_q();
        scl = 1'b1;     wait_q();
        b = sda_bus;
        scl = 1'b0;     wait_q();
    endtask

    task automatic write_byte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(d[i]);
        get_bit(b);
        ack = !b;
    endtask

    task automatic read_byte(output logic [7:0] d, input logic last);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            d[i] = b;
        end
        put_bit(last);
    endtask

    task automatic do_write(input logic [7:0] cmd, input logic [7:0] data [$], input string req);
        logic       ack;
        int         ptr;
        logic [7:0] wm;
        cmp_on = 1'b0;
        send_start();
        write_byte(8'hD2, ack); chk("R2", "write address ack", ack, 1);
        write_byte(cmd, ack);   chk(req, "command ack", ack, 1);
        foreach (data[k]) begin
            write_byte(data[k], ack);
            chk(req, "data ack", ack, 1);
        end
        send_stop();
        ptr = cmd[7] ? int'(cmd[6:0]) : 0;
        foreach (data[k]) begin
            if (cmd[7] || k != 0) begin
                if (ptr < 22) begin
                    wm = bwm(ptr);
                    m[ptr] = (m[ptr] & ~wm) | (data[k] & wm);
                end
                if (ptr < 127) ptr++;
            end
        end
        repeat (4) @(negedge clk);
        cmp_on = 1'b1;
    endtask

    task automatic do_read_byte(input int off, input string req);
        logic       ack;
        logic [7:0] d;
        send_start();
        write_byte(8'hD2, ack);
        write_byte({1'b1, 7'(off)}, ack);
        send_start();
        write_byte(8'hD3, ack); chk("R2", "read address ack", ack, 1);
        read_byte(d, 1'b1);
        send_stop();
        chk(req, $sformatf("byte read offset %0d", off), d, model_byte(off));
        chk("R7", "SDA released after read", sda_bus, 1);
    endtask

    task automatic do_read_block(input logic [7:0] cmd, input int n);
        logic       ack;
        logic [7:0] d;
        send_start();
        write_byte(8'hD2, ack);
        write_byte(cmd, ack);
        send_start();
        write_byte(8'hD3, ack);
        read_byte(d, 1'b0);
        chk("R7", "block count byte", d, m[15]);
        for (int k = 0; k < n; k++) begin
            read_byte(d, k == n - 1);
            chk(k > 21 ? "R9" : "R7", $sformatf("block byte %0d", k), d, model_byte(k));
        end
        send_stop();
        chk("R7", "SDA released after block read", sda_bus, 1);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic       ack;
        logic [7:0] d;
        for (int i = 0; i < 22; i++) m[i] = bdef(i);
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1: power-up values
        chk("R1", "byte 0", cfg[7:0], 8'hEF);
        chk("R1", "byte 11", cfg[95:88], 8'h81);
        chk("R1", "byte 12", cfg[103:96], 8'hA0);
        chk("R1", "byte 15", cfg[127:120], 8'h16);
        chk("R1", "SDA released", sda_bus, 1);
        cmp_on = 1'b1;

        // R6, R1: indexed read of the identification byte
        do_read_byte(11, "R6");

        // R4, R3: indexed write then read back
        do_write(8'h82, '{8'h5A}, "R4");
        do_read_byte(2, "R4");

        // R4: two bytes in one frame land on consecutive offsets
        do_write(8'h93, '{8'hFF, 8'h77}, "R4");
        do_read_byte(20, "R4");

        // R8: masked and read-only bytes
        do_write(8'h81, '{8'hFF}, "R8");
        do_read_byte(1, "R8");
        do_write(8'h8B, '{8'h00}, "R8");
        do_read_byte(11, "R8");
        do_write(8'h85, '{8'h00}, "R8");
        do_read_byte(5, "R8");
        hw_div  = 48'h123456789ABC;
        hw_stat = 5'b01001;
        repeat (4) @(negedge clk);
        do_read_byte(4, "R8");
        do_read_byte(10, "R8");

        // R2: frame to a foreign address gets no acknowledge and writes nothing
        cmp_on = 1'b0;
        send_start();
        write_byte(8'hA0, ack); chk("R2", "foreign address nack", ack, 0);
        write_byte(8'h80, ack); chk("R2", "command after foreign address", ack, 0);
        write_byte(8'h00, ack); chk("R2", "data after foreign address", ack, 0);
        send_stop();
        repeat (4) @(negedge clk);
        cmp_on = 1'b1;
        do_read_byte(0, "R2");

        // R5, R3: sequential write, count byte discarded, nonzero low command bits ignored
        do_write(8'h05, '{8'h03, 8'hA1, 8'hB2, 8'hC3}, "R5");
        // R5: count says three, stop after one
        do_write(8'h00, '{8'h03, 8'h11}, "R5");
        do_read_byte(1, "R5");

        // R9: offsets beyond the bank
        do_write(8'h9E, '{8'h55}, "R9");
        do_write(8'hFE, '{8'h55, 8'h66}, "R9");
        do_read_byte(48, "R9");

        // R7: count register value comes first in a sequential read
        do_write(8'h8F, '{8'h04}, "R7");
        do_read_block(8'h00, 24);
        do_read_block(8'h07, 3);

        // R11: stop in the middle of the address, then in the middle of a data byte
        send_start();
        put_bit(1'b1); put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
        send_stop();
        chk("R11", "SDA released after aborted address", sda_bus, 1);
        cmp_on = 1'b0;
        send_start();
        write_byte(8'hD2, ack);
        write_byte(8'h80, ack);
        put_bit(1'b0); put_bit(1'b0); put_bit(1'b1); put_bit(1'b1); put_bit(1'b0);
        send_stop();
        repeat (4) @(negedge clk);
        cmp_on = 1'b1;
        chk("R11", "byte 0 after aborted data", cfg[7:0], model_byte(0));
        do_read_byte(2, "R11");

        // R11: repeated start keeps the offset chosen by the command
        send_start();
        write_byte(8'hD2, ack);
        write_byte(8'h94, ack);
        send_start();
        write_byte(8'hD3, ack);
        read_byte(d, 1'b0);
        chk("R11", "repeated start first byte", d, model_byte(20));
        read_byte(d, 1'b1);
        chk("R11", "repeated start next byte", d, model_byte(21));
        send_stop();

        repeat (10) @(negedge clk);
        done = 1'b1;
        finish_run();
    end

endmodule